// File: doc/BRIEF.md
# Tunable Phase-Accumulator Frequency Synthesizer

This block produces a low-rate square wave from a fast system clock. A wide phase accumulator adds a step value on every enabled cycle. Its top bit then toggles at the requested rate. The caller asks for a rate as an unsigned integer number of hertz. A registered multiplier scales that number by a fixed-point factor, and the factor is fixed when the block is elaborated. The multiplier's output becomes the step.

The step comes from a multiply by a constant rather than a division at run time. This lets the requested tone change on any cycle, at the cost of one register stage. The accumulator can also be loaded with a phase value, to align or restart the output. A one-cycle pulse marks the start of each output period.

Top module: `phase_synth_top`

## Requirements
- R1: While `rstN` is low, `accOut` is 0, `synthClk` is 0, `periodPulse` is 0 and the step register is 0. The first enabled cycle after reset therefore leaves `accOut` at 0.
- R2: The step equals (`freqHz` × SCALE) >> FRAC_W, with the discarded low bits truncated. SCALE is round(2^(ACC_W+FRAC_W) / SYS_HZ).
- R3: The step register samples `freqHz` on every clock edge. A new frequency affects the accumulator from the second rising edge after it is applied.
- R4: On an edge where `enable` is 1 and `loadPhase` is 0, `accOut` becomes (`accOut` + step) mod 2^ACC_W.
- R5: On an edge where `enable` is 0, `accOut` keeps its value, whatever `loadPhase` and `newPhase` are.
- R6: On an edge where `enable` and `loadPhase` are both 1, `accOut` becomes `newPhase`. Loading takes priority over stepping.
- R7: `synthClk` always equals bit ACC_W-1 of `accOut`.
- R8: `periodPulse` is 1 for exactly the cycles in which `synthClk` is 1 after being 0 in the previous cycle. The number of pulses therefore equals the number of rising edges of `synthClk`.
- R9: With the default sizing (50 MHz system clock, 28-bit accumulator, 8 fraction bits), a 2600 Hz request yields step × SYS_HZ / 2^ACC_W within 0.1 % of 2600.
- R10: Over a run of W enabled cycles from phase 0, the number of `synthClk` rising edges is floor((W × step + 2^(ACC_W-1)) / 2^ACC_W).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows stepping or loading on this edge |
| loadPhase | input | 1 | With `enable`, replaces the accumulator with `newPhase` |
| newPhase | input | ACC_W | Phase value to load |
| freqHz | input | FREQ_W | Requested output rate in whole hertz |
| accOut | output | ACC_W | Current accumulator value |
| synthClk | output | 1 | Synthesized square wave (accumulator top bit) |
| periodPulse | output | 1 | One-cycle marker at each rising edge of `synthClk` |

## Verification
The bench uses the default parameters: a 28-bit accumulator, 8 fraction bits, a 50 MHz nominal rate and a 13-bit frequency input. With these, 261, 440, 2600, 4200, 1 and 8191 Hz all give distinct steps that can be checked exactly. A phase loaded ten counts below the top wraps in a single step. At 4200 Hz, several complete output periods fit within 60,000 cycles, so the edge count and the pulse count can be compared with a closed-form prediction.

// File: rtl/synth_pkg.sv
package synth_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadStb;   // replace accumulator with new phase
    logic stepStb;   // add increment
  } accCtrl_t;

  // round(2^(accW+fracW) / sysHz), integer arithmetic
  function automatic longint scaleFactor(int accW, int fracW, longint sysHz);
    longint num;
    num = longint'(1) << (accW + fracW);
    return (num + sysHz / 2) / sysHz;
  endfunction

  // Number of bits needed to hold value v (at least 1)
  function automatic int bitsFor(longint v);
    int w;
    w = 1;
    while (w < 62 && (longint'(1) << w) <= v) w++;
    return w;
  endfunction

endpackage

// File: rtl/phase_inc_stage.sv
module phase_inc_stage #(
  parameter int     ACC_W  = 28,
  parameter int     FRAC_W = 8,
  parameter int     FREQ_W = 13,
  parameter longint SCALE  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FREQ_W-1:0] freqHz,
  output logic [ACC_W-1:0]  incWord
);
  localparam int SCALE_W = synth_pkg::bitsFor(SCALE);
  localparam int PROD_W  = FREQ_W + SCALE_W;
  localparam int WIDE_W  = (PROD_W > ACC_W + FRAC_W) ? PROD_W : ACC_W + FRAC_W;

  logic [WIDE_W-1:0] product;

  always_comb begin
    product = WIDE_W'(freqHz) * WIDE_W'(SCALE);
  end

  // Registered product; fraction bits dropped (truncation)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) incWord <= '0;
    else       incWord <= product[FRAC_W +: ACC_W];
  end
endmodule

// File: rtl/phase_acc_ctrl.sv
module phase_acc_ctrl (
  input  logic                enable,
  input  logic                loadPhase,
  output synth_pkg::accCtrl_t ctrlOut
);
  always_comb begin
    ctrlOut.loadStb = enable & loadPhase;
    ctrlOut.stepStb = enable & ~loadPhase;
  end
endmodule

// File: rtl/phase_acc_dp.sv
module phase_acc_dp #(
  parameter int ACC_W = 28
) (
  input  logic                clk,
  input  logic                rstN,
  input  synth_pkg::accCtrl_t ctrlIn,
  input  logic [ACC_W-1:0]    newPhase,
  input  logic [ACC_W-1:0]    incWord,
  output logic [ACC_W-1:0]    accOut,
  output logic                synthClk,
  output logic                periodPulse
);
  logic [ACC_W-1:0] accReg;
  logic             prevMsb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg <= '0;
    end else if (ctrlIn.loadStb) begin
      accReg <= newPhase;
    end else if (ctrlIn.stepStb) begin
      accReg <= accReg + incWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevMsb <= 1'b0;
    else       prevMsb <= accReg[ACC_W-1];
  end

  always_comb begin
    accOut      = accReg;
    synthClk    = accReg[ACC_W-1];
    periodPulse = accReg[ACC_W-1] & ~prevMsb;
  end
endmodule

// File: rtl/phase_synth_top.sv
module phase_synth_top #(
  parameter int     ACC_W  = 28,
  parameter int     FRAC_W = 8,
  parameter int     FREQ_W = 13,
  parameter longint SYS_HZ = 50000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              loadPhase,
  input  logic [ACC_W-1:0]  newPhase,
  input  logic [FREQ_W-1:0] freqHz,
  output logic [ACC_W-1:0]  accOut,
  output logic              synthClk,
  output logic              periodPulse
);
  localparam longint SCALE = synth_pkg::scaleFactor(ACC_W, FRAC_W, SYS_HZ);

  synth_pkg::accCtrl_t ctrlBus;
  logic [ACC_W-1:0]    incWord;

  phase_inc_stage #(
    .ACC_W(ACC_W), .FRAC_W(FRAC_W), .FREQ_W(FREQ_W), .SCALE(SCALE)
  ) u_inc (
    .clk(clk), .rstN(rstN), .freqHz(freqHz), .incWord(incWord)
  );

  phase_acc_ctrl u_ctrl (
    .enable(enable), .loadPhase(loadPhase), .ctrlOut(ctrlBus)
  );

  phase_acc_dp #(.ACC_W(ACC_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrlIn(ctrlBus), .newPhase(newPhase),
    .incWord(incWord), .accOut(accOut), .synthClk(synthClk),
    .periodPulse(periodPulse)
  );
endmodule

// File: rtl/phase_synth_chk.sv
module phase_synth_chk #(
  parameter int ACC_W = 28
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             loadPhase,
  input logic [ACC_W-1:0] newPhase,
  input logic [ACC_W-1:0] incWord,
  input logic [ACC_W-1:0] accOut,
  input logic             synthClk,
  input logic             periodPulse
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (accOut == '0 && incWord == '0 && !periodPulse));

  // R4
  step_add_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !loadPhase) |=> accOut == ACC_W'($past(accOut) + $past(incWord)));

  // R5
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable(accOut));

  // R6
  load_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && loadPhase) |=> accOut == $past(newPhase));

  // R7
  msb_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    synthClk == accOut[ACC_W-1]);

  // R8
  pulse_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    periodPulse |-> (synthClk && !$past(synthClk)));

  // R8
  pulse_needed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (synthClk && !$past(synthClk)) |-> periodPulse);
endmodule

bind phase_synth_top phase_synth_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .loadPhase(loadPhase),
  .newPhase(newPhase), .incWord(incWord), .accOut(accOut),
  .synthClk(synthClk), .periodPulse(periodPulse)
);

// File: tb/phase_synth_top_tb.sv
module phase_synth_top_tb;
  localparam int     ACC_W  = 28;
  localparam int     FRAC_W = 8;
  localparam int     FREQ_W = 13;
  localparam longint SYS_HZ = 50000000;
  localparam longint MOD    = longint'(1) << ACC_W;
  localparam int     NVEC   = 6;
  localparam longint FREQ_TAB [NVEC] = '{261, 440, 2600, 4200, 1, 8191};
  localparam int     WIN    = 60000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              enable = 1'b0;
  logic              loadPhase = 1'b0;
  logic [ACC_W-1:0]  newPhase = '0;
  logic [FREQ_W-1:0] freqHz = '0;
  logic [ACC_W-1:0]  accOut;
  logic              synthClk;
  logic              periodPulse;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;  // 125 MHz

  phase_synth_top #(
    .ACC_W(ACC_W), .FRAC_W(FRAC_W), .FREQ_W(FREQ_W), .SYS_HZ(SYS_HZ)
  ) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .loadPhase(loadPhase),
    .newPhase(newPhase), .freqHz(freqHz), .accOut(accOut),
    .synthClk(synthClk), .periodPulse(periodPulse)
  );

  function automatic longint expStep(longint f);
    longint sc;
    sc = ((longint'(1) << (ACC_W + FRAC_W)) + SYS_HZ / 2) / SYS_HZ;
    return ((f * sc) >> FRAC_W) % MOD;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    longint st, phase;
    int edges, pulses;
    logic prevClk;

    // Reset state
    repeat (3) @(negedge clk);
    check("R1 acc in reset", longint'(accOut), 0);
    check("R1 clk in reset", longint'(synthClk), 0);
    check("R1 pulse in reset", longint'(periodPulse), 0);

    // Release; new frequency takes one registered stage
    rstN = 1'b1; freqHz = 440; enable = 1'b1;
    tick();
    check("R1 cleared step gives 0", longint'(accOut), 0);
    tick();
    check("R3 step after latency", longint'(accOut), expStep(440));

    // Vector table walk
    for (int i = 0; i < NVEC; i++) begin
      st = expStep(FREQ_TAB[i]);
      phase = longint'(accOut);
      enable = 1'b0; freqHz = FREQ_W'(FREQ_TAB[i]);
      tick();
      check("R5 hold while disabled", longint'(accOut), phase);
      enable = 1'b1; loadPhase = 1'b1; newPhase = '0;
      tick();
      check("R6 load zero", longint'(accOut), 0);
      loadPhase = 1'b0;
      tick();
      check("R2 step value", longint'(accOut), st);
      tick();
      tick();
      check("R4 three steps", longint'(accOut), (3 * st) % MOD);
      check("R7 msb", longint'(synthClk), ((3 * st) % MOD) >> (ACC_W - 1));
      if (FREQ_TAB[i] == 2600) begin
        // R9: |step*SYS - f*2^N| * 1000 <= f*2^N
        phase = longint'(accOut) / 3 * SYS_HZ - 2600 * MOD;
        if (phase < 0) phase = -phase;
        check("R9 2600 Hz tolerance", longint'(phase * 1000 <= 2600 * MOD), 1);
      end
    end

    // Disabled load ignored
    phase = longint'(accOut);
    enable = 1'b0; loadPhase = 1'b1; newPhase = 123;
    tick();
    check("R5 load ignored when disabled", longint'(accOut), phase);

    // Wrap (freqHz = 8191 from last vector); use 4200
    freqHz = 4200; enable = 1'b0; loadPhase = 1'b0;
    tick();
    st = expStep(4200);
    enable = 1'b1; loadPhase = 1'b1; newPhase = ACC_W'(MOD - 10);
    tick();
    check("R6 load near top", longint'(accOut), MOD - 10);
    loadPhase = 1'b0;
    tick();
    check("R4 wrap", longint'(accOut), (MOD - 10 + st) % MOD);

    // Pulse
    loadPhase = 1'b1; newPhase = ACC_W'(MOD / 2 - 1);
    tick();
    check("R8 no pulse with msb low", longint'(periodPulse), 0);
    loadPhase = 1'b0;
    tick();
    check("R8 pulse on rise", longint'(periodPulse), 1);
    check("R7 clk high", longint'(synthClk), 1);
    tick();
    check("R8 pulse one cycle", longint'(periodPulse), 0);

    // Long window edge count
    loadPhase = 1'b1; newPhase = '0;
    tick();
    loadPhase = 1'b0;
    edges = 0; pulses = 0; prevClk = 1'b0;
    for (int k = 0; k < WIN; k++) begin
      tick();
      if (synthClk && !prevClk) edges++;
      if (periodPulse) pulses++;
      prevClk = synthClk;
    end
    check("R10 edge count", longint'(edges),
          (longint'(WIN) * st + MOD / 2) / MOD);
    check("R8 pulses equal edges", longint'(pulses), longint'(edges));

    // Mid-run reset
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1 async clear", longint'(accOut), 0);
    tick();
    rstN = 1'b1; freqHz = 4200; enable = 1'b1;
    tick();
    check("R1 step cleared after reset", longint'(accOut), 0);
    tick();
    check("R3 step resumes", longint'(accOut), st);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule